// File: doc/BRIEF.md
# Transmit Line Driver Protection Controller

This block guards a transmit line driver. It sits between the gain word that software programs and the digital attenuator in front of the DAC. It holds the gain code that is actually applied. Whenever a current-sense comparator reports an over-current condition, it backs that gain off one step per pacing tick. The pacing tick lets the analog loop settle between steps. Once the comparator clears, reduction stops and the reduced gain is held until a new programmed value is accepted.

In parallel, it watches a digitized die temperature. It drops the power-amplifier enable when the temperature climbs above a trip point. It only restores the enable once the temperature has cooled below a lower release point, so a die hovering near the trip point does not oscillate. It also reports a two-bit thermal zone. That zone is filtered so that it moves only after the raw classification has held steady for a programmable number of ticks.

Top module: `txdrv_guard`

## Requirements
- R1: After synchronous reset the applied gain is 0, the amplifier enable is 1 and the zone code is 0.
- R2: On a cycle with `step_tick` high and `ilim_hi` high, the applied gain drops by exactly one code. It saturates at 0 and never wraps. Code 31 is full scale, and the attenuation is (31 - code) dB.
- R3: On a cycle with `step_tick` low, the applied gain does not change.
- R4: On a tick with `ilim_hi` low and no pending programmed value, the applied gain is held: reduction has stopped.
- R5: A write (`gain_wr` high) is accepted only if `ilim_hi` is low in that same cycle. A rejected write leaves the applied gain unchanged at every later tick.
- R6: An accepted value becomes the applied gain at the first tick in a later cycle than the write. A write in the same cycle as a tick waits for the next tick. A reduction tick discards any pending value.
- R7: The amplifier enable falls in the cycle after `temp_code` is strictly greater than `TSD_SET` (default 170).
- R8: Once the enable is low, it stays low until `temp_code` is strictly below `TSD_CLR` (default 140). It rises in the following cycle.
- R9: The raw zone is 0 below 70, 1 from 70 to 99, 2 from 100 to 124, and 3 at 125 and above.
- R10: The zone output changes only on a tick. It takes the raw zone once the same raw zone has been sampled on `hold_ticks` consecutive ticks, with 0 treated as 1. The run count saturates at 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_tick | input | 1 | Pacing pulse for gain steps and zone filtering |
| ilim_hi | input | 1 | Current-sense comparator: sensed level above limit |
| gain_wr | input | 1 | Programmed-gain write strobe |
| gain_prog | input | 5 | Programmed gain code |
| temp_code | input | 8 | Digitized die temperature in degrees C |
| hold_ticks | input | 4 | Consecutive ticks required before the zone moves |
| gain_eff | output | 5 | Applied transmit gain code |
| pa_en | output | 1 | Power-amplifier enable |
| zone | output | 2 | Filtered thermal zone |

## Verification
The hardest situation to reach is the interplay between a pending programmed value and an over-current episode. A value written while the limit is clear, followed by a tick with the limit set, must be discarded rather than applied later. The stimulus sets up that exact ordering, and also lands a write on the same cycle as a tick. Temperature is swept up and down across every code so the trip and release points are each crossed from both sides. The zone filter is driven with alternating temperatures at a hold length above one, so that runs are broken before they complete.

// File: rtl/txdrv_guard_pkg.sv
package txdrv_guard_pkg;

    localparam int GAIN_W = 5;
    typedef logic [GAIN_W-1:0] gain_t;
    localparam gain_t GAIN_FLOOR = '0;

    typedef enum logic [1:0] {
        ZONE_COOL = 2'd0,
        ZONE_WARM = 2'd1,
        ZONE_HOT  = 2'd2,
        ZONE_CRIT = 2'd3
    } zone_t;

    // A programmed gain waiting for the next pacing tick
    typedef struct packed {
        gain_t value;
        logic  valid;
    } gain_req_t;

    function automatic zone_t temp_to_zone(input int unsigned t,
                                           input int unsigned lim_warm,
                                           input int unsigned lim_hot,
                                           input int unsigned lim_crit);
        zone_t z;
        if (t >= lim_crit)     z = ZONE_CRIT;
        else if (t >= lim_hot) z = ZONE_HOT;
        else if (t >= lim_warm) z = ZONE_WARM;
        else                   z = ZONE_COOL;
        return z;
    endfunction

    function automatic gain_t gain_step_down(input gain_t g);
        return (g == GAIN_FLOOR) ? GAIN_FLOOR : gain_t'(g - gain_t'(1));
    endfunction

endpackage

// File: rtl/txdrv_gain_stepper.sv
module txdrv_gain_stepper
    import txdrv_guard_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  step_tick,
    input  logic  ilim_hi,
    input  logic  gain_wr,
    input  gain_t gain_prog,
    output gain_t gain_eff
);
    gain_req_t pend_q;
    gain_t     gain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gain_q <= GAIN_FLOOR;
            pend_q <= '0;
        end else begin
            if (step_tick) begin
                if (ilim_hi) begin
                    gain_q       <= gain_step_down(gain_q);
                    pend_q.valid <= 1'b0;
                end else if (pend_q.valid) begin
                    gain_q       <= pend_q.value;
                    pend_q.valid <= 1'b0;
                end
            end
            // placed last so a write alongside a tick stays pending
            if (gain_wr && !ilim_hi) begin
                pend_q <= '{value: gain_prog, valid: 1'b1};
            end
        end
    end

    assign gain_eff = gain_q;
endmodule

// File: rtl/txdrv_thermal_trip.sv
module txdrv_thermal_trip #(
    parameter int TEMP_W  = 8,
    parameter int TSD_SET = 170,
    parameter int TSD_CLR = 140
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [TEMP_W-1:0] temp_code,
    output logic              pa_en
);
    localparam logic [TEMP_W-1:0] SET_LVL = TEMP_W'(TSD_SET);
    localparam logic [TEMP_W-1:0] CLR_LVL = TEMP_W'(TSD_CLR);

    logic en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= 1'b1;
        end else if (en_q && (temp_code > SET_LVL)) begin
            en_q <= 1'b0;
        end else if (!en_q && (temp_code < CLR_LVL)) begin
            en_q <= 1'b1;
        end
    end

    assign pa_en = en_q;
endmodule

// File: rtl/txdrv_zone_filter.sv
module txdrv_zone_filter
    import txdrv_guard_pkg::*;
#(
    parameter int TEMP_W  = 8,
    parameter int HOLD_W  = 4,
    parameter int ZONE_T1 = 70,
    parameter int ZONE_T2 = 100,
    parameter int ZONE_T3 = 125
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step_tick,
    input  logic [TEMP_W-1:0] temp_code,
    input  logic [HOLD_W-1:0] hold_ticks,
    output zone_t             zone
);
    localparam logic [HOLD_W-1:0] RUN_MAX = '1;

    zone_t             raw_zone;
    zone_t             cand_q;
    zone_t             zone_q;
    logic [HOLD_W-1:0] run_q;
    logic [HOLD_W-1:0] run_nxt;

    always_comb begin
        raw_zone = temp_to_zone(int'(temp_code), ZONE_T1, ZONE_T2, ZONE_T3);
        if (raw_zone != cand_q)   run_nxt = HOLD_W'(1);
        else if (run_q == RUN_MAX) run_nxt = RUN_MAX;
        else                       run_nxt = run_q + HOLD_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cand_q <= ZONE_COOL;
            zone_q <= ZONE_COOL;
            run_q  <= '0;
        end else if (step_tick) begin
            cand_q <= raw_zone;
            run_q  <= run_nxt;
            if (run_nxt >= hold_ticks) zone_q <= raw_zone;
        end
    end

    assign zone = zone_q;
endmodule

// File: rtl/txdrv_guard.sv
module txdrv_guard
    import txdrv_guard_pkg::*;
#(
    parameter int TEMP_W  = 8,
    parameter int HOLD_W  = 4,
    parameter int ZONE_T1 = 70,
    parameter int ZONE_T2 = 100,
    parameter int ZONE_T3 = 125,
    parameter int TSD_SET = 170,
    parameter int TSD_CLR = 140
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step_tick,
    input  logic              ilim_hi,
    input  logic              gain_wr,
    input  logic [4:0]        gain_prog,
    input  logic [TEMP_W-1:0] temp_code,
    input  logic [HOLD_W-1:0] hold_ticks,
    output logic [4:0]        gain_eff,
    output logic              pa_en,
    output logic [1:0]        zone
);
    gain_t gain_w;
    zone_t zone_w;

    txdrv_gain_stepper u_gain (
        .clk       (clk),
        .rst       (rst),
        .step_tick (step_tick),
        .ilim_hi   (ilim_hi),
        .gain_wr   (gain_wr),
        .gain_prog (gain_t'(gain_prog)),
        .gain_eff  (gain_w)
    );

    txdrv_thermal_trip #(
        .TEMP_W  (TEMP_W),
        .TSD_SET (TSD_SET),
        .TSD_CLR (TSD_CLR)
    ) u_trip (
        .clk       (clk),
        .rst       (rst),
        .temp_code (temp_code),
        .pa_en     (pa_en)
    );

    txdrv_zone_filter #(
        .TEMP_W  (TEMP_W),
        .HOLD_W  (HOLD_W),
        .ZONE_T1 (ZONE_T1),
        .ZONE_T2 (ZONE_T2),
        .ZONE_T3 (ZONE_T3)
    ) u_zone (
        .clk        (clk),
        .rst        (rst),
        .step_tick  (step_tick),
        .temp_code  (temp_code),
        .hold_ticks (hold_ticks),
        .zone       (zone_w)
    );

    assign gain_eff = gain_w;
    assign zone     = zone_w;
endmodule

// File: rtl/txdrv_guard_chk.sv
module txdrv_guard_chk #(
    parameter int TEMP_W  = 8,
    parameter int HOLD_W  = 4,
    parameter int TSD_SET = 170,
    parameter int TSD_CLR = 140
) (
    input logic              clk,
    input logic              rst,
    input logic              step_tick,
    input logic              ilim_hi,
    input logic [TEMP_W-1:0] temp_code,
    input logic [4:0]        gain_eff,
    input logic              pa_en,
    input logic [1:0]        zone
);
    // R2: one step down per over-current tick, floor at zero
    assert_step_down_R2: assert property (@(posedge clk) disable iff (rst)
        (step_tick && ilim_hi && gain_eff != 5'd0) |=> (gain_eff == $past(gain_eff) - 5'd1));

    assert_no_wrap_R2: assert property (@(posedge clk) disable iff (rst)
        (step_tick && ilim_hi && gain_eff == 5'd0) |=> (gain_eff == 5'd0));

    // R3: gain frozen between ticks
    assert_gain_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !step_tick |=> $stable(gain_eff));

    // R7: enable falls only after an over-temperature sample
    assert_trip_cause_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(pa_en) |-> ($past(temp_code) > TEMP_W'(TSD_SET)));

    // R8: enable returns only after cooling below release point
    assert_release_cause_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(pa_en) |-> ($past(temp_code) < TEMP_W'(TSD_CLR)));

    // R10: zone moves only on a tick
    assert_zone_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !step_tick |=> $stable(zone));
endmodule

bind txdrv_guard txdrv_guard_chk #(
    .TEMP_W  (TEMP_W),
    .HOLD_W  (HOLD_W),
    .TSD_SET (TSD_SET),
    .TSD_CLR (TSD_CLR)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .step_tick (step_tick),
    .ilim_hi   (ilim_hi),
    .temp_code (temp_code),
    .gain_eff  (gain_eff),
    .pa_en     (pa_en),
    .zone      (zone)
);

// File: tb/tb_txdrv_guard.sv
module tb_txdrv_guard;
    logic       clk = 1'b0;
    logic       rst;
    logic       step_tick, ilim_hi, gain_wr;
    logic [4:0] gain_prog;
    logic [7:0] temp_code;
    logic [3:0] hold_ticks;
    logic [4:0] gain_eff;
    logic       pa_en;
    logic [1:0] zone;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // bench model state
    int m_gain, m_pend, m_pv, m_pa, m_zone, m_cand, m_cnt;

    always #5 clk = ~clk;

    txdrv_guard dut (
        .clk(clk), .rst(rst), .step_tick(step_tick), .ilim_hi(ilim_hi),
        .gain_wr(gain_wr), .gain_prog(gain_prog), .temp_code(temp_code),
        .hold_ticks(hold_ticks), .gain_eff(gain_eff), .pa_en(pa_en), .zone(zone)
    );

    function automatic int raw_zone(input int t);
        if (t < 70)  return 0;
        if (t < 100) return 1;
        if (t < 125) return 2;
        return 3;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // drive one cycle, advance model, compare after the edge
    task automatic step(input bit tk, input bit il, input bit wr, input int prog,
                        input int t, input int hold, input string greq);
        int nc;
        int h;
        step_tick = tk; ilim_hi = il; gain_wr = wr;
        gain_prog = 5'(prog); temp_code = 8'(t); hold_ticks = 4'(hold);
        if (tk) begin
            if (il) begin
                m_gain = (m_gain == 0) ? 0 : m_gain - 1;
                m_pv = 0;
            end else if (m_pv != 0) begin
                m_gain = m_pend;
                m_pv = 0;
            end
            nc = (raw_zone(t) == m_cand) ? ((m_cnt == 15) ? 15 : m_cnt + 1) : 1;
            m_cand = raw_zone(t);
            m_cnt = nc;
            h = (hold == 0) ? 1 : hold;
            if (nc >= h) m_zone = m_cand;
        end
        if (wr && !il) begin
            m_pend = prog;
            m_pv = 1;
        end
        if (m_pa != 0 && t > 170)      m_pa = 0;
        else if (m_pa == 0 && t < 140) m_pa = 1;
        @(posedge clk);
        @(negedge clk);
        check(greq, int'(gain_eff), m_gain);
        check("R7/R8 pa_en", int'(pa_en), m_pa);
        check("R9/R10 zone", int'(zone), m_zone);
    endtask

    initial begin
        #(10 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; step_tick = 0; ilim_hi = 0; gain_wr = 0;
        gain_prog = 0; temp_code = 8'd25; hold_ticks = 4'd1;
        m_gain = 0; m_pend = 0; m_pv = 0; m_pa = 1; m_zone = 0; m_cand = 0; m_cnt = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check("R1 gain", int'(gain_eff), 0);
        check("R1 pa_en", int'(pa_en), 1);
        check("R1 zone", int'(zone), 0);

        // R6: exhaustive write then apply at a later tick
        for (int v = 0; v < 32; v++) begin
            step(0, 0, 1, v, 25, 1, "R6 write");
            step(0, 0, 0, 0, 25, 1, "R3 no tick");
            step(1, 0, 0, 0, 25, 1, "R6 apply");
            check("R6 applied value", int'(gain_eff), v);
        end
        // R6: write on the same cycle as a tick waits one more tick
        step(1, 0, 1, 12, 25, 1, "R6 same-cycle write");
        check("R6 not yet applied", int'(gain_eff), 31);
        step(1, 0, 0, 0, 25, 1, "R6 next tick");
        check("R6 applied later", int'(gain_eff), 12);

        // R2: full-scale down to floor and beyond, gaps between ticks
        step(0, 0, 1, 31, 25, 1, "R6 write");
        step(1, 0, 0, 0, 25, 1, "R6 apply");
        for (int k = 0; k < 35; k++) begin
            step(1, 1, 0, 0, 25, 1, "R2 step");
            check("R2 step value", int'(gain_eff), (30 - k < 0) ? 0 : 30 - k);
            step(0, 1, 0, 0, 25, 1, "R3 gap");
        end
        // R4: limit clear, tick holds the floor
        step(1, 0, 0, 0, 25, 1, "R4 hold");
        check("R4 reduction stopped", int'(gain_eff), 0);

        // R5: rejected write has no later effect
        step(0, 0, 1, 20, 25, 1, "R6 write");
        step(1, 0, 0, 0, 25, 1, "R6 apply");
        step(0, 1, 1, 5, 25, 1, "R5 rejected write");
        step(1, 0, 0, 0, 25, 1, "R5 after reject");
        step(1, 0, 0, 0, 25, 1, "R5 after reject");
        check("R5 gain unchanged", int'(gain_eff), 20);

        // R6: pending value discarded by a reduction tick
        step(0, 0, 1, 28, 25, 1, "R6 write");
        step(1, 1, 0, 0, 25, 1, "R6 discard");
        step(1, 0, 0, 0, 25, 1, "R6 discard held");
        check("R6 pending discarded", int'(gain_eff), 19);

        // R7/R8/R9: full temperature sweep up and down
        for (int t = 0; t < 256; t++) step(1, 0, 0, 0, t, 1, "R3 gain");
        check("R7 tripped hot", int'(pa_en), 0);
        for (int t = 255; t >= 0; t--) step(1, 0, 0, 0, t, 1, "R3 gain");
        check("R8 released cool", int'(pa_en), 1);
        check("R9 zone cool", int'(zone), 0);

        // R10: hold length 3, broken runs and a complete run
        for (int k = 0; k < 6; k++) step(1, 0, 0, 0, (k % 2) ? 110 : 20, 3, "R3 gain");
        check("R10 broken runs hold", int'(zone), 0);
        for (int k = 0; k < 3; k++) step(1, 0, 0, 0, 130, 3, "R3 gain");
        check("R10 run complete", int'(zone), 3);
        for (int k = 0; k < 4; k++) step(0, 0, 0, 0, 80, 3, "R3 gain");
        check("R10 no tick no move", int'(zone), 3);
        for (int k = 0; k < 20; k++) step(1, 0, 0, 0, 80 + 20 * (k / 7), 0, "R3 gain");
        for (int k = 0; k < 20; k++) step(k % 3 == 0, 0, 0, 0, 60 + 3 * k, 15, "R3 gain");

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule